// File: doc/BRIEF.md
# Reference Cycle And Seconds Counter

This block keeps two free-running timestamps that software reads through a small 32-bit register window. The first counts cycles of a 25 MHz reference. It only updates when a qualifying clock enable marks the end of one 640 ns period, and each update adds 16 to it. The second counts whole seconds since the last cold reset. The cycle count rolls over at 25,000,000, which is exactly one second, and each rollover carries one into the seconds count.

The cycle timestamp is read-only. A write to it leaves the count as it was and sets a sticky error bit in a status register. Software clears that bit by writing a one to it. The step size, the wrap value, the seconds width and the data width are parameters, so a small configuration can be checked exhaustively.

Register map (word index on `bus_addr`):

| Index | Contents | Write effect |
|-------|----------|--------------|
| 0 | Cycle count | Ignored; sets the error bit |
| 1 | Seconds count | Ignored; no flag |
| 2 | Status, bit 0 = error flag | Writing 1 to bit 0 clears the flag |
| 3 | Unused, reads 0 | Ignored |

Top module: `refclk_stamp`

## Requirements
- R1: After `rst_n` is low, the cycle count, the seconds count and the error flag are all zero.
- R2: On each rising clock edge with `tick_en` high, the cycle count grows by STEP (default 16). With `tick_en` low, it holds its value.
- R3: Bits log2(STEP)-1:0 of the cycle count (bits 3:0 by default) always read zero.
- R4: When a tick would bring the cycle count to WRAP (default 25,000,000), the count becomes zero on that same edge. The count never reaches or exceeds WRAP.
- R5: The seconds count (index 1) grows by one on exactly the edge at which the cycle count wraps, and at no other edge.
- R6: The seconds count is SEC_W bits wide (default 32) and wraps from all ones to zero.
- R7: A write (`bus_wr` high) to index 0 leaves the cycle count unchanged apart from its normal tick step. It also sets status bit 0 on the next edge.
- R8: Status bit 0 stays set until a write to index 2 with `bus_wdata[0]`=1 clears it. A write to index 2 with `bus_wdata[0]`=0 leaves it set.
- R9: A write to index 0 on the same edge as a wrapping tick still lets the cycle count wrap to zero and the seconds count advance, and it still sets the flag.
- R10: Reading index 1 returns the seconds count and reading index 3 returns zero. Writes to index 1 leave the seconds count unchanged and do not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low cold reset, synchronous |
| tick_en | input | 1 | Clock enable, high for one cycle per 640 ns period |
| bus_addr | input | 2 | Register word index |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |

## Verification
Two functions can fall on the same edge: a reference tick that wraps the cycle count (and so advances the seconds count), and a rejected software write to that same cycle register. The bench sets this up with a small configuration (STEP 16, WRAP 64, a 4-bit seconds count). It ticks until the cycle count sits one step below the wrap, then issues the write together with the next tick. It then expects the cycle count to be zero, the seconds count to be one higher, and the error flag to be set. All three are read back through the register window.

// File: rtl/refclk_stamp_pkg.sv
package refclk_stamp_pkg;
   localparam int REG_AW = 2;
   typedef enum logic [REG_AW-1:0] {
      IDX_CYCLES  = 2'd0,
      IDX_SECONDS = 2'd1,
      IDX_STATUS  = 2'd2,
      IDX_SPARE   = 2'd3
   } reg_idx_e;
   localparam int ERR_BIT = 0;
endpackage

// File: rtl/refclk_cycle_ctr.sv
module refclk_cycle_ctr #(
   parameter int STEP = 16,
   parameter int WRAP = 25_000_000,
   parameter int CW   = $clog2(WRAP)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   output logic [CW-1:0] count,
   output logic          carry
);
   localparam int LOW = $clog2(STEP);
   localparam logic [CW-1:0] LAST = CW'(WRAP - STEP);
   localparam logic [CW-1:0] INC  = CW'(STEP);

   generate
      if (STEP < 2 || (1 << LOW) != STEP) begin : g_bad_step
         $error("STEP must be a power of two of at least 2");
      end
      if (WRAP % STEP != 0) begin : g_bad_wrap
         $error("WRAP must be a multiple of STEP");
      end
   endgenerate

   assign carry = tick && (count == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)      count <= '0;
      else if (carry)  count <= '0;
      else if (tick)   count <= count + INC;
   end

   AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      count[LOW-1:0] == '0); // R3
   AST_BELOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      32'(count) < WRAP); // R4
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count)); // R2
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      carry |=> count == '0); // R4
endmodule

// File: rtl/refclk_sec_ctr.sv
module refclk_sec_ctr #(
   parameter int SEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             carry_in,
   output logic [SEC_W-1:0] seconds
);
   generate
      if (SEC_W < 1) begin : g_bad_w
         $error("SEC_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        seconds <= '0;
      else if (carry_in) seconds <= seconds + 1'b1;
   end

   AST_SEC_ONLY_ON_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_in |=> $stable(seconds)); // R5
   AST_SEC_MOVES_ON_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      carry_in |=> !$stable(seconds)); // R5
endmodule

// File: rtl/refclk_err_flag.sv
module refclk_err_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)     flag <= 1'b0;
      else if (set_i) flag <= 1'b1;
      else if (clr_i) flag <= 1'b0;
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_i) |=> flag); // R8
   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag); // R7
endmodule

// File: rtl/refclk_stamp.sv
module refclk_stamp
   import refclk_stamp_pkg::*;
#(
   parameter int STEP   = 16,
   parameter int WRAP   = 25_000_000,
   parameter int SEC_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int CW = $clog2(WRAP);

   generate
      if (DATA_W < CW || DATA_W < SEC_W) begin : g_bad_data
         $error("DATA_W too narrow for the counters");
      end
   endgenerate

   logic [CW-1:0]    cyc;
   logic [SEC_W-1:0] sec;
   logic             carry;
   logic             err;
   logic             wr_cyc;
   logic             clr_err;

   assign wr_cyc  = bus_wr && (bus_addr == IDX_CYCLES);
   assign clr_err = bus_wr && (bus_addr == IDX_STATUS) && bus_wdata[ERR_BIT];

   refclk_cycle_ctr #(.STEP(STEP), .WRAP(WRAP), .CW(CW)) u_cyc (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .count(cyc), .carry(carry)
   );

   refclk_sec_ctr #(.SEC_W(SEC_W)) u_sec (
      .clk(clk), .rst_n(rst_n), .carry_in(carry), .seconds(sec)
   );

   refclk_err_flag u_err (
      .clk(clk), .rst_n(rst_n), .set_i(wr_cyc), .clr_i(clr_err), .flag(err)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         IDX_CYCLES:  bus_rdata = DATA_W'(cyc);
         IDX_SECONDS: bus_rdata = DATA_W'(sec);
         IDX_STATUS:  bus_rdata[ERR_BIT] = err;
         default:     bus_rdata = '0;
      endcase
   end

   AST_CYC_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cyc && !tick_en) |=> $stable(cyc)); // R7
   AST_WRAP_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && $past(cyc) != '0 && cyc == '0) |-> $past(carry)); // R5
endmodule

// File: tb/refclk_stamp_tb.sv
`timescale 1ns/1ps
module refclk_stamp_tb;
   localparam int STEP = 16, WRAP = 64, SEC_W = 4, DW = 32;
   localparam int PER_SEC = WRAP / STEP;

   logic clk = 0, rst_n = 0, tick_en = 0, bus_wr = 0;
   logic [1:0] bus_addr = 0;
   logic [DW-1:0] bus_wdata = 0, bus_rdata;
   int nchk = 0, nfail = 0, tot = 0;
   bit done = 0;

   always #5 clk = ~clk;

   refclk_stamp #(.STEP(STEP), .WRAP(WRAP), .SEC_W(SEC_W), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic t, input logic w, input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      tick_en = t; bus_wr = w; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      if (t) tot++;
      @(negedge clk);
      tick_en = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
      bus_addr = a; #1; v = bus_rdata;
   endtask

   function automatic logic [DW-1:0] exp_cyc(); return DW'((tot % PER_SEC) * STEP); endfunction
   function automatic logic [DW-1:0] exp_sec(); return DW'((tot / PER_SEC) % (1 << SEC_W)); endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      rd(0, v); check("R1 cycles", v, 0);
      rd(1, v); check("R1 seconds", v, 0);
      rd(2, v); check("R1 flag", v, 0);

      // sweep through more than one full seconds wrap (R2 R4 R5 R6)
      for (int n = 1; n <= 80; n++) begin
         step(1, 0, 0, 0);
         rd(0, v); check("R2 R4 cycles", v, exp_cyc());
         check("R3 low bits", {28'd0, v[3:0]}, 0);
         rd(1, v); check("R5 R6 seconds", v, exp_sec());
      end

      // no tick: hold (R2)
      for (int k = 0; k < 5; k++) step(0, 0, 0, 0);
      rd(0, v); check("R2 hold", v, exp_cyc());

      // write to cycles ignored, flag set (R7)
      step(1, 0, 0, 0);
      step(0, 1, 0, 32'hFFFF_FFF0);
      rd(0, v); check("R7 cycles unchanged", v, exp_cyc());
      rd(2, v); check("R7 flag set", v, 1);

      // clearing (R8)
      step(0, 1, 2, 0);
      rd(2, v); check("R8 write0 keeps", v, 1);
      step(1, 0, 0, 0);
      rd(2, v); check("R8 sticky", v, 1);
      step(0, 1, 2, 1);
      rd(2, v); check("R8 cleared", v, 0);

      // seconds write ignored, unused index (R10)
      step(0, 1, 1, 32'hA);
      rd(1, v); check("R10 seconds unchanged", v, exp_sec());
      rd(2, v); check("R10 no flag", v, 0);
      rd(3, v); check("R10 spare zero", v, 0);

      // write coinciding with wrapping tick (R9)
      while ((tot % PER_SEC) != PER_SEC - 1) step(1, 0, 0, 0);
      rd(0, v); check("R9 pre", v, DW'(WRAP - STEP));
      step(1, 1, 0, 32'h30);
      rd(0, v); check("R9 cycles wrapped", v, 0);
      rd(1, v); check("R9 seconds advanced", v, exp_sec());
      rd(2, v); check("R9 flag", v, 1);

      // reset again (R1)
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1; tot = 0;
      rd(0, v); check("R1 cycles after reset", v, 0);
      rd(1, v); check("R1 seconds after reset", v, 0);
      rd(2, v); check("R1 flag after reset", v, 0);

      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule